// File: doc/BRIEF.md
# Clock Source Switch Sequencer

This block decides the order in which a processor clock moves between four inputs: the system reference, a 32 kHz clock, a first fast oscillator, and two operating points of a second fast oscillator. It drives the select lines of an external glitch-free source mux and the code of an external post-divider. It also requests a reload of the stored trim code of the fast oscillator whenever an operating point of that oscillator is entered. The mux cells, the divider cells and the trim search are outside the block. Each write is shown as a one-cycle strobe together with the new value.

Requests come from a 3-bit source code or from host suspend and resume pulses. A running sequence is never interrupted. Requests that arrive while one runs wait in a small queue and are served in the order they arrived. When reset is released, the block leaves the system reference selected and then moves on its own to the high-speed point of the second oscillator.

Top module: `clk_source_sequencer`

## Requirements
- R1: While reset is held and at release, muxSel is 0 (system reference), divSel is 0 (divide-by-1), busy is 0, and the divWe, selWe and trimLoad strobes are low.
- R2: After reset the block runs, without any request, the full high-speed sequence of R5. It ends with muxSel 2 and divSel 0.
- R3: Request code 0 writes divider 0 and then select 0. Code 1 (32 kHz) writes divider 0 and then select 1. Code 2 (first oscillator) writes divider 0 and then select 3.
- R4: Request codes 5, 6 and 7 are unknown and act as code 0: divider 0, then select 0.
- R5: Code 3 is the low-speed point and code 4 is the high-speed point. Each first parks the clock (divider 0, then select 0). It then pulses trimLoad, with trimPoint 0 for the low-speed point and 1 for the high-speed point. After that it writes the divider (1 = divide-by-2 for low speed, 0 for high speed) and finally writes select 2.
- R6: In a fast-point sequence, the divider write strobe comes exactly SETTLE_CYC+1 cycles after the trimLoad strobe.
- R7: Every selWe strobe comes in the cycle right after a divWe strobe. The two never share a cycle.
- R8: A suspendEvt pulse requests the low-speed point (as code 3). A resumeEvt pulse requests the high-speed point (as code 4).
- R9: When several request sources pulse in the same cycle, only one request is taken. resumeEvt wins over suspendEvt, and suspendEvt wins over reqValid.
- R10: busy is high in every cycle that carries a divWe, selWe or trimLoad strobe. It is low once all queued work is done.
- R11: Requests that arrive during a sequence are carried out after it, in arrival order. Up to QUEUE_DEPTH of them are held, and a request that arrives when the queue is full is dropped.
- R12: muxSel changes only in a cycle with selWe, and divSel changes only in a cycle with divWe. trimLoad is pulsed only while muxSel is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | One-cycle pulse: queue the source code on reqSrc |
| reqSrc | input | 3 | Requested source code (0 sys, 1 32 kHz, 2 osc-1, 3 low point, 4 high point) |
| suspendEvt | input | 1 | Host suspend pulse |
| resumeEvt | input | 1 | Host resume pulse |
| divSel | output | 1 | Divider code: 0 divide-by-1, 1 divide-by-2 |
| muxSel | output | 2 | Source select: 0 sys, 1 32 kHz, 2 osc-2, 3 osc-1 |
| divWe | output | 1 | Strobe: divSel has just been written |
| selWe | output | 1 | Strobe: muxSel has just been written |
| trimLoad | output | 1 | Strobe: reload the stored trim of trimPoint |
| trimPoint | output | 1 | Operating point of the trim reload: 0 low, 1 high |
| busy | output | 1 | A switch sequence is in progress |

## Verification
The properties assume that each request input is a clean pulse. They also assume that the settle counter of a sequence is not disturbed, because a sequence, once begun, always runs through to its end. The queue-full drop is the only place where extra stimulus is thrown away. The driver keeps track of how full the queue is, so it expects results only from requests that the queue accepted. Same-cycle collisions are driven on purpose, and only to exercise the priority of R9. Every other stimulus pulses a single request source and lasts one cycle.

// File: rtl/clk_seq_pkg.sv
package clk_seq_pkg;
  localparam int REQ_W = 3;
  localparam int MUX_W = 2;
  localparam int DIV_W = 1;

  localparam logic [REQ_W-1:0] REQ_SYS     = 3'd0;
  localparam logic [REQ_W-1:0] REQ_SLOW    = 3'd1;
  localparam logic [REQ_W-1:0] REQ_OSC1    = 3'd2;
  localparam logic [REQ_W-1:0] REQ_FAST_LO = 3'd3;
  localparam logic [REQ_W-1:0] REQ_FAST_HI = 3'd4;

  localparam logic [MUX_W-1:0] MUX_SYS  = 2'd0;
  localparam logic [MUX_W-1:0] MUX_SLOW = 2'd1;
  localparam logic [MUX_W-1:0] MUX_OSC2 = 2'd2;
  localparam logic [MUX_W-1:0] MUX_OSC1 = 2'd3;

  localparam logic [DIV_W-1:0] DIV_BY1 = 1'b0;
  localparam logic [DIV_W-1:0] DIV_BY2 = 1'b1;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic loadTarget;
    logic parkDiv;
    logic parkSel;
    logic trimLd;
    logic tgtDiv;
    logic tgtSel;
  } seqStrobe_t;

  function automatic logic isFastCode(input logic [REQ_W-1:0] code);
    return (code == REQ_FAST_LO) || (code == REQ_FAST_HI);
  endfunction
endpackage

// File: rtl/clk_seq_queue.sv
module clk_seq_queue #(
  parameter int DEPTH = 4,
  parameter int W     = 3
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         push,
  input  logic [W-1:0] pushData,
  input  logic         pop,
  output logic [W-1:0] popData,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  slots [DEPTH];
  logic [PW-1:0] wrPtr, rdPtr;
  logic [CW-1:0] count;
  logic          doPush, doPop;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign doPush  = push && !full;
  assign doPop   = pop && !empty;
  assign popData = slots[rdPtr];

  function automatic logic [PW-1:0] nextPtr(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      if (doPush && !doPop)      count <= count + 1'b1;
      else if (doPop && !doPush) count <= count - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (doPush) slots[wrPtr] <= pushData;
  end
endmodule

// File: rtl/clk_seq_ctrl.sv
module clk_seq_ctrl
  import clk_seq_pkg::*;
#(
  parameter int SETTLE_CYC = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             qEmpty,
  input  logic [REQ_W-1:0] qData,
  output logic             qPop,
  output logic [REQ_W-1:0] nextCode,
  output seqStrobe_t       strobe,
  output logic             busy
);
  localparam int CNT_W = $clog2(SETTLE_CYC + 1) + 1;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PARK_DIV, ST_PARK_SEL, ST_TRIM,
    ST_SETTLE, ST_TGT_DIV, ST_TGT_SEL, ST_DONE
  } seqState_e;

  seqState_e   state, stateNext;
  logic        initPending;
  logic        haveWork;
  logic [CNT_W-1:0] settleCnt;

  assign haveWork = initPending || !qEmpty;
  assign nextCode = initPending ? REQ_FAST_HI : qData;
  assign qPop     = (state == ST_IDLE) && !initPending && !qEmpty;
  assign busy     = (state != ST_IDLE);

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: if (haveWork) begin
        strobe.loadTarget = 1'b1;
        stateNext = isFastCode(nextCode) ? ST_PARK_DIV : ST_TGT_DIV;
      end
      ST_PARK_DIV: begin strobe.parkDiv = 1'b1; stateNext = ST_PARK_SEL; end
      ST_PARK_SEL: begin strobe.parkSel = 1'b1; stateNext = ST_TRIM;     end
      ST_TRIM:     begin strobe.trimLd  = 1'b1; stateNext = ST_SETTLE;   end
      ST_SETTLE:   if (settleCnt == CNT_W'(SETTLE_CYC - 1)) stateNext = ST_TGT_DIV;
      ST_TGT_DIV:  begin strobe.tgtDiv  = 1'b1; stateNext = ST_TGT_SEL;  end
      ST_TGT_SEL:  begin strobe.tgtSel  = 1'b1; stateNext = ST_DONE;     end
      ST_DONE:     stateNext = ST_IDLE;
      default:     stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      initPending <= 1'b1;
      settleCnt   <= '0;
    end else begin
      state <= stateNext;
      if (state == ST_IDLE) initPending <= 1'b0;
      if (state == ST_TRIM)        settleCnt <= '0;
      else if (state == ST_SETTLE) settleCnt <= settleCnt + 1'b1;
    end
  end
endmodule

// File: rtl/clk_seq_datapath.sv
module clk_seq_datapath
  import clk_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strobe,
  input  logic [REQ_W-1:0] nextCode,
  output logic [DIV_W-1:0] divSel,
  output logic [MUX_W-1:0] muxSel,
  output logic             divWe,
  output logic             selWe,
  output logic             trimLoad,
  output logic             trimPoint
);
  logic [REQ_W-1:0] targetCode;
  logic [DIV_W-1:0] tgtDivCode;
  logic [MUX_W-1:0] tgtMuxCode;

  always_comb begin
    unique case (targetCode)
      REQ_SLOW:    begin tgtDivCode = DIV_BY1; tgtMuxCode = MUX_SLOW; end
      REQ_OSC1:    begin tgtDivCode = DIV_BY1; tgtMuxCode = MUX_OSC1; end
      REQ_FAST_LO: begin tgtDivCode = DIV_BY2; tgtMuxCode = MUX_OSC2; end
      REQ_FAST_HI: begin tgtDivCode = DIV_BY1; tgtMuxCode = MUX_OSC2; end
      default:     begin tgtDivCode = DIV_BY1; tgtMuxCode = MUX_SYS;  end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      targetCode <= REQ_SYS;
      divSel     <= DIV_BY1;
      muxSel     <= MUX_SYS;
      divWe      <= 1'b0;
      selWe      <= 1'b0;
      trimLoad   <= 1'b0;
      trimPoint  <= 1'b0;
    end else begin
      divWe    <= strobe.parkDiv || strobe.tgtDiv;
      selWe    <= strobe.parkSel || strobe.tgtSel;
      trimLoad <= strobe.trimLd;
      if (strobe.loadTarget) targetCode <= nextCode;
      if (strobe.parkDiv)     divSel <= DIV_BY1;
      else if (strobe.tgtDiv) divSel <= tgtDivCode;
      if (strobe.parkSel)     muxSel <= MUX_SYS;
      else if (strobe.tgtSel) muxSel <= tgtMuxCode;
      if (strobe.trimLd) trimPoint <= (targetCode == REQ_FAST_HI);
    end
  end
endmodule

// File: rtl/clk_source_sequencer.sv
module clk_source_sequencer
  import clk_seq_pkg::*;
#(
  parameter int QUEUE_DEPTH = 4,
  parameter int SETTLE_CYC  = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [2:0] reqSrc,
  input  logic       suspendEvt,
  input  logic       resumeEvt,
  output logic       divSel,
  output logic [1:0] muxSel,
  output logic       divWe,
  output logic       selWe,
  output logic       trimLoad,
  output logic       trimPoint,
  output logic       busy
);
  logic             qPush, qPop, qEmpty, qFull;
  logic [REQ_W-1:0] qIn, qOut, nextCode;
  seqStrobe_t       strobe;

  // one request per cycle: resume, then suspend, then direct request
  assign qPush = reqValid || suspendEvt || resumeEvt;
  assign qIn   = resumeEvt  ? REQ_FAST_HI :
                 suspendEvt ? REQ_FAST_LO : reqSrc;

  clk_seq_queue #(.DEPTH(QUEUE_DEPTH), .W(REQ_W)) u_queue (
    .clk, .rstN, .push(qPush), .pushData(qIn), .pop(qPop),
    .popData(qOut), .empty(qEmpty), .full(qFull)
  );

  clk_seq_ctrl #(.SETTLE_CYC(SETTLE_CYC)) u_ctrl (
    .clk, .rstN, .qEmpty, .qData(qOut), .qPop, .nextCode, .strobe, .busy
  );

  clk_seq_datapath u_dp (
    .clk, .rstN, .strobe, .nextCode, .divSel, .muxSel,
    .divWe, .selWe, .trimLoad, .trimPoint
  );
endmodule

// File: rtl/clk_source_sequencer_chk.sv
module clk_source_sequencer_chk #(
  parameter int SETTLE_CYC = 8
) (
  input logic       clk,
  input logic       rstN,
  input logic       divSel,
  input logic [1:0] muxSel,
  input logic       divWe,
  input logic       selWe,
  input logic       trimLoad,
  input logic       busy
);
  localparam int CW = $clog2(SETTLE_CYC + 3) + 1;

  logic [CW-1:0] sinceTrim;
  logic          armed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sinceTrim <= '0;
      armed     <= 1'b0;
    end else if (trimLoad) begin
      sinceTrim <= CW'(1);
      armed     <= 1'b1;
    end else if (divWe) begin
      armed <= 1'b0;
    end else if (armed) begin
      sinceTrim <= sinceTrim + 1'b1;
    end
  end

  // R6
  settle_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (divWe && armed) |-> (sinceTrim == CW'(SETTLE_CYC + 1)));

  // R7
  div_then_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    selWe |-> $past(divWe));

  // R7
  no_shared_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(divWe && selWe));

  // R10
  strobe_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (divWe || selWe || trimLoad) |-> busy);

  // R12
  mux_change_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(muxSel) |-> selWe);

  // R12
  div_change_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(divSel) |-> divWe);

  // R12
  park_before_trim_chk: assert property (@(posedge clk) disable iff (!rstN)
    trimLoad |-> (muxSel == 2'd0));
endmodule

bind clk_source_sequencer clk_source_sequencer_chk #(.SETTLE_CYC(SETTLE_CYC)) u_chk (
  .clk(clk), .rstN(rstN), .divSel(divSel), .muxSel(muxSel), .divWe(divWe),
  .selWe(selWe), .trimLoad(trimLoad), .busy(busy)
);

// File: tb/clk_source_sequencer_bench.sv
module clk_source_sequencer_bench;
  localparam int SETTLE = 8;
  localparam int DEPTH  = 4;
  localparam int KIND_DIV = 0, KIND_SEL = 1, KIND_TRIM = 2;

  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 1'b0, suspendEvt = 1'b0, resumeEvt = 1'b0;
  logic [2:0] reqSrc = '0;
  logic divSel, divWe, selWe, trimLoad, trimPoint, busy;
  logic [1:0] muxSel;

  int checks = 0, failures = 0, cycle = 0, lastTrim = -1;
  bit done = 0;

  typedef struct { int kind; int val; string tag; } expItem_t;
  expItem_t expQ[$];

  clk_source_sequencer #(.QUEUE_DEPTH(DEPTH), .SETTLE_CYC(SETTLE)) u_clk_source_sequencer (
    .clk, .rstN, .reqValid, .reqSrc, .suspendEvt, .resumeEvt,
    .divSel, .muxSel, .divWe, .selWe, .trimLoad, .trimPoint, .busy
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cycle <= cycle + 1;

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, expv, cycle);
    end
  endtask

  task automatic expectItem(input int kind, input int val, input string tag);
    expItem_t it;
    it.kind = kind; it.val = val; it.tag = tag;
    expQ.push_back(it);
  endtask

  // expected write order for one request code, from the requirements
  task automatic expectSeq(input int code, input string tag);
    if (code == 3 || code == 4) begin            // R5
      expectItem(KIND_DIV, 0, tag);
      expectItem(KIND_SEL, 0, tag);
      expectItem(KIND_TRIM, (code == 4) ? 1 : 0, tag);
      expectItem(KIND_DIV, (code == 3) ? 1 : 0, tag);
      expectItem(KIND_SEL, 2, tag);
    end else begin                               // R3, R4
      expectItem(KIND_DIV, 0, tag);
      expectItem(KIND_SEL, (code == 1) ? 1 : (code == 2) ? 3 : 0, tag);
    end
  endtask

  task automatic pulse(input bit res, input bit sus, input bit rv, input int code);
    @(negedge clk);
    resumeEvt = res; suspendEvt = sus; reqValid = rv; reqSrc = 3'(code);
    @(negedge clk);
    resumeEvt = 0; suspendEvt = 0; reqValid = 0;
  endtask

  task automatic waitIdle();
    int quiet = 0;
    repeat (3) @(negedge clk);
    while (quiet < 3) begin
      @(negedge clk);
      if (!busy && expQ.size() == 0) quiet++; else quiet = 0;
    end
    check(busy == 0, "R10 busy low when idle", busy, 0);
  endtask

  task automatic checkFinal(input int mux, input int dv, input string tag);
    check(muxSel == 2'(mux), {tag, " final muxSel"}, muxSel, mux);
    check(divSel == 1'(dv), {tag, " final divSel"}, divSel, dv);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && !done) begin
      if (divWe) begin
        expItem_t it;
        check(busy, "R10 busy with divWe", busy, 1);
        if (lastTrim >= 0) begin
          check(cycle - lastTrim == SETTLE + 1, "R6 settle gap", cycle - lastTrim, SETTLE + 1);
          lastTrim = -1;
        end
        if (expQ.size() == 0) check(0, "R11 unexpected divider write", divSel, -1);
        else begin
          it = expQ.pop_front();
          check(it.kind == KIND_DIV && divSel == 1'(it.val), {it.tag, " divider write"}, divSel, it.val);
        end
      end
      if (selWe) begin
        expItem_t it;
        check(busy, "R10 busy with selWe", busy, 1);
        if (expQ.size() == 0) check(0, "R11 unexpected select write", muxSel, -1);
        else begin
          it = expQ.pop_front();
          check(it.kind == KIND_SEL && muxSel == 2'(it.val), {it.tag, " select write"}, muxSel, it.val);
        end
      end
      if (trimLoad) begin
        expItem_t it;
        lastTrim = cycle;
        check(muxSel == 0, "R12 parked at trim", muxSel, 0);
        if (expQ.size() == 0) check(0, "R11 unexpected trim load", trimPoint, -1);
        else begin
          it = expQ.pop_front();
          check(it.kind == KIND_TRIM && trimPoint == 1'(it.val), {it.tag, " trim point"}, trimPoint, it.val);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycle, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(muxSel == 0, "R1 reset muxSel", muxSel, 0);
    check(divSel == 0, "R1 reset divSel", divSel, 0);
    check(busy == 0, "R1 reset busy", busy, 0);
    check(!(divWe || selWe || trimLoad), "R1 reset strobes", divWe, 0);
    expectSeq(4, "R2 init");
    rstN = 1'b1;
    waitIdle();
    checkFinal(2, 0, "R2");

    pulse(0, 0, 1, 1); expectSeq(1, "R3 slow"); waitIdle(); checkFinal(1, 0, "R3");
    pulse(0, 0, 1, 2); expectSeq(2, "R3 osc1"); waitIdle(); checkFinal(3, 0, "R3");
    pulse(0, 0, 1, 0); expectSeq(0, "R3 sys");  waitIdle(); checkFinal(0, 0, "R3");
    pulse(0, 0, 1, 1); expectSeq(1, "R3 slow"); waitIdle();
    pulse(0, 0, 1, 6); expectSeq(6, "R4 unknown"); waitIdle(); checkFinal(0, 0, "R4");
    pulse(0, 0, 1, 3); expectSeq(3, "R5 low direct"); waitIdle(); checkFinal(2, 1, "R5");

    pulse(0, 1, 0, 0); expectSeq(3, "R8 suspend"); waitIdle(); checkFinal(2, 1, "R8");
    pulse(1, 0, 0, 0); expectSeq(4, "R8 resume");  waitIdle(); checkFinal(2, 0, "R8");

    // R9 collisions
    pulse(0, 1, 1, 1); expectSeq(3, "R9 suspend over req"); waitIdle(); checkFinal(2, 1, "R9");
    pulse(1, 1, 1, 2); expectSeq(4, "R9 resume over all");  waitIdle(); checkFinal(2, 0, "R9");

    // R11 queue order and drop when full
    pulse(0, 0, 1, 3); expectSeq(3, "R11 head");
    @(negedge clk);
    check(busy == 1, "R10 busy during sequence", busy, 1);
    pulse(0, 0, 1, 1); expectSeq(1, "R11 q1");
    pulse(0, 0, 1, 2); expectSeq(2, "R11 q2");
    pulse(0, 0, 1, 7); expectSeq(7, "R11 q3");
    pulse(0, 0, 1, 4); expectSeq(4, "R11 q4");
    pulse(0, 0, 1, 1);                         // R11 dropped: queue full
    waitIdle();
    checkFinal(2, 0, "R11");
    check(expQ.size() == 0, "R11 scoreboard drained", expQ.size(), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule